// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory is ready for normal traffic. It first drives a long, steady period of no-operation commands with clock enable and every data mask line held high. It then closes all banks with a single precharge-all and waits out the row precharge time. Next it issues a configurable number of auto-refresh commands, each separated by a refresh cycle time, and finally loads the mode register with a configured word. Once the mode-register settling time has passed, it raises a done flag and keeps driving no-operation so that the normal controller can take over the pins.

All delays are cycle counts set by parameters. The initial quiet period is given in microseconds and converted using a clock-frequency parameter. A refresh count below eight is rejected when the design is elaborated. Asserting reset at any time, including after done, restarts the whole sequence from the quiet period.

Command encodings on (cs_n, ras_n, cas_n, we_n): no-operation = 0111, precharge = 0010, auto-refresh = 0001, mode register set = 0000.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and throughout the quiet period, the outputs drive no-operation (0111), cke is 1, every dqm bit is 1, and init_done is 0.
- R2: The first command other than no-operation is issued exactly WAIT_US*CLK_MHZ clock edges after reset is released. Counting starts with the first rising edge after release as edge 1.
- R3: The first command is a precharge (0010) with addr bit 10 high, so that all banks are closed.
- R4: The first auto-refresh (0001) appears exactly T_RP cycles after the precharge cycle.
- R5: Consecutive auto-refresh commands are exactly T_RC cycles apart, and only no-operation is driven between them.
- R6: Exactly N_REF auto-refresh commands are issued before the mode register set.
- R7: The mode register set (0000) is issued T_RC cycles after the last auto-refresh, with addr equal to MODE_WORD and ba equal to 0. It is the only mode register set in the sequence.
- R8: init_done rises exactly T_RSC cycles after the mode-register-set cycle and stays high. From that cycle on, only no-operation is driven.
- R9: Asserting reset at any point, during the sequence or after done, clears init_done at once and restarts the sequence from the quiet period with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| cke | output | 1 | Clock enable to the SDRAM, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, zero during the whole sequence |
| addr | output | ADDR_W | Address; bit 10 high for precharge-all, MODE_WORD during mode register set |
| dqm | output | DQM_W | Data mask lines, all high |
| init_done | output | 1 | High once the sequence is complete |

## Verification
The bench walks a table of the expected commands and cycle offsets and checks every cycle between them for stray commands. An off-by-one in any gap counter would shift a precharge, a refresh or the mode-register set by one cycle and be caught. A wrong refresh count would show up either as a mode-register set where a refresh was expected, or as an extra refresh. Further checks cover a missing A10 on precharge, a wrong mode word, and done rising one cycle early or late. Reset is applied in the middle of the refresh train and again after done. A design that kept its refresh tally or its done flag across reset would then show a shortened second sequence or a stale done.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_MHZ = 125,
  parameter int WAIT_US = 500,
  parameter int T_RP = 3,
  parameter int T_RC = 8,
  parameter int T_RSC = 2,
  parameter int N_REF = 8,
  parameter int ADDR_W = 12,
  parameter int BA_W = 2,
  parameter int DQM_W = 8,
  parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              init_done
);

  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int CNT_W = $clog2(WAIT_CYC + T_RP + T_RC + T_RSC + 1);
  localparam int REF_W = $clog2(N_REF + 1);
  localparam int ALL_BIT = 10;

  if (N_REF < 8) begin : g_bad_nref
    $error("N_REF must be at least 8");
  end
  if (T_RP < 2 || T_RC < 2 || T_RSC < 2 || WAIT_CYC < 2) begin : g_bad_gap
    $error("gap counts must be at least 2");
  end
  if (ADDR_W <= ALL_BIT) begin : g_bad_addr
    $error("ADDR_W must exceed 10");
  end

  typedef enum logic [2:0] {
    S_WAIT, S_PRE, S_TRP, S_REF, S_TRC, S_MRS, S_TRSC, S_DONE
  } phase_t;

  phase_t           ph;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] nref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= S_WAIT;
      cnt  <= '0;
      nref <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      unique case (ph)
        S_WAIT: if (cnt == CNT_W'(WAIT_CYC - 1)) begin ph <= S_PRE; cnt <= '0; end
        S_PRE:  begin ph <= S_TRP; cnt <= '0; end
        S_TRP:  if (cnt == CNT_W'(T_RP - 2)) begin ph <= S_REF; cnt <= '0; end
        S_REF:  begin ph <= S_TRC; cnt <= '0; nref <= nref + 1'b1; end
        S_TRC:  if (cnt == CNT_W'(T_RC - 2)) begin
                  ph  <= (nref == REF_W'(N_REF)) ? S_MRS : S_REF;
                  cnt <= '0;
                end
        S_MRS:  begin ph <= S_TRSC; cnt <= '0; end
        S_TRSC: if (cnt == CNT_W'(T_RSC - 2)) begin ph <= S_DONE; cnt <= '0; end
        S_DONE: cnt <= '0;
        default: ph <= S_WAIT;
      endcase
    end
  end

  assign cke       = 1'b1;
  assign dqm       = '1;
  assign cs_n      = 1'b0;
  assign ras_n     = !(ph == S_PRE || ph == S_REF || ph == S_MRS);
  assign cas_n     = !(ph == S_REF || ph == S_MRS);
  assign we_n      = !(ph == S_PRE || ph == S_MRS);
  assign ba        = '0;
  assign init_done = (ph == S_DONE);

  always_comb begin
    addr = '0;
    if (ph == S_PRE) addr[ALL_BIT] = 1'b1;
    else if (ph == S_MRS) addr = MODE_WORD;
  end

  wire is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
  wire is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
  wire is_mrs = !cs_n && !ras_n && !cas_n && !we_n;
  wire is_nop = !cs_n &&  ras_n &&  cas_n &&  we_n;

  logic [CNT_W-1:0] gap_mon;
  logic             ref_seen;
  logic             mrs_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_mon  <= '0;
      ref_seen <= 1'b0;
      mrs_seen <= 1'b0;
    end else begin
      gap_mon <= is_ref ? CNT_W'(1) : gap_mon + 1'b1;
      if (is_ref) ref_seen <= 1'b1;
      if (is_mrs) mrs_seen <= 1'b1;
    end
  end

  assert_pre_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr[ALL_BIT]);
  assert_ref_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && ref_seen) |-> gap_mon == CNT_W'(T_RC));
  assert_ref_then_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> is_nop);
  assert_ref_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nref <= REF_W'(N_REF));
  assert_mrs_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (addr == MODE_WORD && ba == '0 && !mrs_seen));
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && is_nop));
  assert_done_after_mrs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> mrs_seen);

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int CLK_MHZ = 125;
  localparam int WAIT_US = 1;
  localparam int T_RP = 3;
  localparam int T_RC = 7;
  localparam int T_RSC = 2;
  localparam int N_REF = 8;
  localparam logic [11:0] MODE = 12'h033;
  localparam int W = CLK_MHZ * WAIT_US;
  localparam int NEV = N_REF + 2;
  localparam int C_NOP = 0, C_PRE = 1, C_REF = 2, C_MRS = 3, C_BAD = 7;
  localparam int EV_CMD [0:9] = '{C_PRE, C_REF, C_REF, C_REF, C_REF,
                                   C_REF, C_REF, C_REF, C_REF, C_MRS};
  localparam int DONE_AT = W + T_RP + (N_REF - 1) * T_RC + T_RC + T_RSC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [11:0] addr;
  logic [7:0] dqm;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_RP(T_RP), .T_RC(T_RC),
    .T_RSC(T_RSC), .N_REF(N_REF), .ADDR_W(12), .BA_W(2), .DQM_W(8), .MODE_WORD(MODE))
  u_dut (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .init_done(done));

  function automatic int ev_cycle(int i);
    if (i == 0) return W;
    return W + T_RP + (i - 1) * T_RC;
  endfunction

  function automatic int cmd_now();
    case ({cs_n, ras_n, cas_n, we_n})
      4'b0111: return C_NOP;
      4'b0010: return C_PRE;
      4'b0001: return C_REF;
      4'b0000: return C_MRS;
      default: return C_BAD;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic walk(int stop_at, bit full);
    int ev = 0;
    int nref = 0;
    int stray = 0;
    for (int k = 0; k <= stop_at; k++) begin
      int c = cmd_now();
      if (k < W && (c != C_NOP || !cke || dqm != 8'hFF || done)) stray++;
      if (c != C_NOP) begin
        if (c == C_REF) nref++;
        if (ev < NEV) begin
          check(k == ev_cycle(ev) && c == EV_CMD[ev], ev == 0 ? "R2" : (c == C_MRS ? "R7" : "R5"),
                k * 10 + c, ev_cycle(ev) * 10 + EV_CMD[ev]);
          if (ev == 0) begin
            check(addr[10] == 1'b1, "R3", addr[10], 1);
          end
          if (ev == 1) check(k - ev_cycle(0) == T_RP, "R4", k - ev_cycle(0), T_RP);
          if (c == C_MRS) check(addr == MODE && ba == 2'b00, "R7", addr, MODE);
        end else begin
          check(1'b0, "R8", c, C_NOP);
        end
        ev++;
      end
      if (full && (k == DONE_AT - 1 || k == DONE_AT || k == stop_at))
        check(done == (k >= DONE_AT), "R8", done, k >= DONE_AT);
      if (k < stop_at) step();
    end
    check(stray == 0, "R1", stray, 0);
    if (full) begin
      check(nref == N_REF, "R6", nref, N_REF);
      check(ev == NEV, "R6", ev, NEV);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_now() == C_NOP && cke && dqm == 8'hFF && !done, "R1 reset", cmd_now(), C_NOP);
    rst_n = 1'b1;
    #1;
    walk(DONE_AT + 20, 1'b1);

    rst_n = 1'b0;
    #1;
    check(!done, "R9 reset after done", done, 0);
    check(cmd_now() == C_NOP, "R9 reset after done", cmd_now(), C_NOP);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    walk(ev_cycle(4) + 2, 1'b0);

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(cmd_now() == C_NOP && !done, "R9 mid reset", cmd_now(), C_NOP);
    rst_n = 1'b1;
    #1;
    walk(DONE_AT + 10, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule